// File: doc/BRIEF.md
# Error-Triggered Link Snapshot Recorder

This block watches a decoded trigger link, made up of one timing bit and one message bit per clock, and writes every cycle into a small ring of sample registers while it is armed. A single-cycle error strobe comes from separate protocol-checking logic. It freezes the ring around the faulty cycle. A placement mode decides how much of the window lies before the error and how much after it. The block raises a sticky error flag that drives a front-panel indicator. It also reports where the faulty sample sits in the frozen window.

When the ring is frozen, the stored samples leave through a valid/ready stream, oldest first, and the final beat is marked. The consumer may hold ready low for any number of cycles. While a beat is offered and not accepted, that beat stays unchanged. No beat is lost and no beat is repeated. A rearm pulse clears the flag and the counters, drops any readout in progress and starts a new recording. Errors that arrive while the ring is frozen are not stored, but a saturating counter records how many there were.

Top module: `snapcap_top`

## Requirements
- R1: After reset, err_flag is 0, frozen is 0, rd_valid is 0 and drop_count is 0, and the block is armed.
- R2: While armed, every cycle without rearm writes one sample with bit 0 = link_a, bit 1 = link_b and bit 2 = err_strobe. Only the most recent DEPTH samples written since the last rearm are kept.
- R3: With cap_mode 2'b00, the ring freezes on the edge that samples the error. The error sample is the last one in the window, so err_index = window length - 1.
- R4: With cap_mode 2'b01 or 2'b11, DEPTH/2 more samples are written after the error, and then the ring freezes. With a full window, err_index = DEPTH/2 - 1.
- R5: With cap_mode 2'b10, DEPTH-1 more samples are written after the error, and then the ring freezes. With a full window, err_index = 0.
- R6: err_flag rises on the edge that samples the first error strobe in the armed state, and stays high until rearm.
- R7: Error strobes during the post-error window are stored with their mark bit set, and they do not restart the window. Error strobes while frozen are not stored. They raise drop_count by one each, and drop_count saturates at its maximum value.
- R8: While frozen, rd_valid offers exactly the stored samples, oldest first, and rd_last is set on the final one. After the final beat is accepted, rd_valid stays low.
- R9: While rd_valid is high and rd_ready is low, rd_data holds its value on the next cycle.
- R10: Rearm clears err_flag, drop_count and the stored window, and ends any readout. It returns the block to the armed state. The sample of the rearm cycle is not stored. An error strobe in the same cycle as rearm is neither recorded nor counted.
- R11: If fewer than DEPTH samples were written since rearm, the window holds only those samples, and err_index counts from the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_a | input | 1 | Decoded timing bit of the link |
| link_b | input | 1 | Decoded message bit of the link |
| err_strobe | input | 1 | One-cycle pulse from the error checker |
| cap_mode | input | 2 | Placement: 00 error at end, 01/11 error centred, 10 error at start |
| rearm | input | 1 | Clears the capture and starts a new recording |
| err_flag | output | 1 | Sticky error indication for the front panel |
| frozen | output | 1 | Capture complete, window available |
| err_index | output | log2(DEPTH) | Position of the error sample counted from the oldest sample |
| drop_count | output | CW | Saturating count of errors ignored while frozen |
| rd_valid | output | 1 | Readout beat available |
| rd_ready | input | 1 | Consumer accepts the beat |
| rd_data | output | 3 | Stored sample {mark, link_b, link_a} |
| rd_last | output | 1 | Final beat of the window |

## Verification
Two collisions are provoked deliberately. In the first, rearm and an error strobe arrive in the same cycle while the block is armed. The bench expects the flag to stay low and the block to stay armed. It then confirms, through a later readout, that the collision cycle never entered the window. In the second, rearm arrives while a readout is part way through. The bench expects rd_valid, the flag and the drop count to read zero on the following cycle. Error strobes also fall inside the post-error window and after the freeze. The bench judges these from the mark bits in the read-back samples and from drop_count.

// File: rtl/snapcap_pkg.sv
package snapcap_pkg;

  typedef enum logic [1:0] {
    ST_ARMED  = 2'd0,
    ST_POST   = 2'd1,
    ST_FROZEN = 2'd2
  } cap_state_t;

  typedef struct packed {
    logic err_mark;
    logic chan_b;
    logic chan_a;
  } snap_sample_t;

  // Samples still to be written after the error cycle, per placement mode.
  function automatic int unsigned tail_len(input logic [1:0] mode, input int unsigned depth);
    case (mode)
      2'b00:   return 0;
      2'b10:   return depth - 1;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/snapcap_ring.sv
module snapcap_ring
  import snapcap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         clr_fill,
  input  snap_sample_t wr_data,
  input  logic [AW-1:0] rd_addr,
  output snap_sample_t rd_data,
  output logic [AW-1:0] wr_ptr,
  output logic [AW:0]   fill
);

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  snap_sample_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else begin
      if (we) wr_ptr <= wr_ptr + AW'(1);
      if (clr_fill)              fill <= '0;
      else if (we && fill != FULL) fill <= fill + (AW+1)'(1);
    end
  end

  assign rd_data = mem[rd_addr];

  // R2: the window never claims more samples than the ring holds
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  // R2: each write advances the ring by exactly one slot
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> wr_ptr == $past(wr_ptr) + AW'(1));

endmodule

// File: rtl/snapcap_ctrl.sv
module snapcap_ctrl
  import snapcap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_strobe,
  input  logic          rearm,
  input  logic [1:0]    cap_mode,
  input  logic [AW-1:0] wr_ptr,
  output logic          we,
  output logic          frozen,
  output logic          err_flag,
  output logic [AW-1:0] err_addr,
  output logic [CW-1:0] drop_count
);

  localparam logic [CW-1:0] DROP_MAX = '1;

  cap_state_t    state;
  logic [AW-1:0] remain;
  logic [AW-1:0] tail;

  assign tail   = AW'(tail_len(cap_mode, DEPTH));
  assign we     = !rearm && (state == ST_ARMED || state == ST_POST);
  assign frozen = (state == ST_FROZEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_ARMED;
      remain     <= '0;
      err_flag   <= 1'b0;
      err_addr   <= '0;
      drop_count <= '0;
    end else if (rearm) begin
      state      <= ST_ARMED;
      remain     <= '0;
      err_flag   <= 1'b0;
      drop_count <= '0;
    end else begin
      case (state)
        ST_ARMED: begin
          if (err_strobe) begin
            err_flag <= 1'b1;
            err_addr <= wr_ptr;
            remain   <= tail;
            state    <= (tail == '0) ? ST_FROZEN : ST_POST;
          end
        end
        ST_POST: begin
          remain <= remain - AW'(1);
          if (remain == AW'(1)) state <= ST_FROZEN;
        end
        ST_FROZEN: begin
          if (err_strobe && drop_count != DROP_MAX) drop_count <= drop_count + CW'(1);
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  // R6: first error while armed raises the flag and latches the slot
  a_r6_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ARMED && err_strobe && !rearm |=> err_flag && err_addr == $past(wr_ptr));

  // R6: the flag is sticky until rearm
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !rearm |=> err_flag);

  // R3: pre placement freezes right after the error cycle
  a_r3_pre_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ARMED && err_strobe && !rearm && cap_mode == 2'b00 |=> frozen);

  // R7: a frozen error below saturation adds exactly one to the count
  a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && err_strobe && !rearm && drop_count != DROP_MAX |=> drop_count == $past(drop_count) + CW'(1));

  // R10: rearm clears the capture state on the next cycle
  a_r10_rearm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !err_flag && !frozen && drop_count == '0);

endmodule

// File: rtl/snapcap_reader.sv
module snapcap_reader #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frozen,
  input  logic [AW:0]   fill,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] err_addr,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] err_index
);

  logic [AW:0]   rd_cnt;
  logic [AW-1:0] oldest;

  assign oldest    = wr_ptr - fill[AW-1:0];
  assign rd_addr   = oldest + rd_cnt[AW-1:0];
  assign err_index = err_addr - oldest;
  assign rd_valid  = frozen && (rd_cnt < fill);
  assign rd_last   = rd_valid && (rd_cnt == fill - (AW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rd_cnt <= '0;
    else if (!frozen)              rd_cnt <= '0;
    else if (rd_valid && rd_ready) rd_cnt <= rd_cnt + (AW+1)'(1);
  end

  // R9: a stalled beat stays put unless the capture is dropped
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> !frozen || (rd_valid && $stable(rd_addr)));

  // R8: nothing is offered after the final beat is taken
  a_r8_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_last |=> !rd_valid);

endmodule

// File: rtl/snapcap_top.sv
module snapcap_top
  import snapcap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_a,
  input  logic          link_b,
  input  logic          err_strobe,
  input  logic [1:0]    cap_mode,
  input  logic          rearm,
  output logic          err_flag,
  output logic          frozen,
  output logic [AW-1:0] err_index,
  output logic [CW-1:0] drop_count,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [2:0]    rd_data,
  output logic          rd_last
);

  logic          we;
  logic [AW-1:0] wr_ptr;
  logic [AW:0]   fill;
  logic [AW-1:0] err_addr;
  logic [AW-1:0] rd_addr;
  snap_sample_t  wr_sample;
  snap_sample_t  rd_sample;

  assign wr_sample = '{err_mark: err_strobe, chan_b: link_b, chan_a: link_a};
  assign rd_data   = rd_sample;

  snapcap_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .rearm(rearm),
    .cap_mode(cap_mode), .wr_ptr(wr_ptr), .we(we), .frozen(frozen),
    .err_flag(err_flag), .err_addr(err_addr), .drop_count(drop_count)
  );

  snapcap_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .we(we), .clr_fill(rearm), .wr_data(wr_sample),
    .rd_addr(rd_addr), .rd_data(rd_sample), .wr_ptr(wr_ptr), .fill(fill)
  );

  snapcap_reader #(.DEPTH(DEPTH)) u_reader (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .fill(fill), .wr_ptr(wr_ptr),
    .err_addr(err_addr), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_last(rd_last), .rd_addr(rd_addr), .err_index(err_index)
  );

  // R7: a frozen ring takes no writes until rearm
  a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !rearm |=> frozen && $stable(wr_ptr));

endmodule

// File: tb/sim_snapcap_top.sv
module sim_snapcap_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 16;
  localparam int CW = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int DMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_a = 1'b0, link_b = 1'b0, err_strobe = 1'b0, rearm = 1'b0, rd_ready = 1'b0;
  logic [1:0] cap_mode = 2'b00;
  logic err_flag, frozen, rd_valid, rd_last;
  logic [AW-1:0] err_index;
  logic [CW-1:0] drop_count;
  logic [2:0] rd_data;

  always #2.5 clk = ~clk;

  snapcap_top #(.DEPTH(DEPTH), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .link_a(link_a), .link_b(link_b),
    .err_strobe(err_strobe), .cap_mode(cap_mode), .rearm(rearm),
    .err_flag(err_flag), .frozen(frozen), .err_index(err_index),
    .drop_count(drop_count), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  logic [31:0] cyc = '0;
  int total = 0;
  logic [2:0] hist[$];
  logic [2:0] expq[$];
  bit lastq[$];
  bit stall_seen = 1'b0;
  logic [2:0] stall_data = '0;
  logic [2:0] mon_exp;
  bit mon_last;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: one link cycle, optionally recorded in the reference history.
  task automatic drive(input bit e, input bit rec);
    logic a, b;
    a = cyc[0] ^ cyc[2];
    b = cyc[1] ^ cyc[3];
    link_a = a; link_b = b; err_strobe = e;
    if (rec) begin
      hist.push_back({e, b, a});
      total++;
      if (hist.size() > DEPTH) void'(hist.pop_front());
    end
    cyc++;
    @(negedge clk);
    err_strobe = 1'b0;
  endtask

  task automatic do_rearm(input bit with_err);
    rd_ready = 1'b0; rearm = 1'b1; err_strobe = with_err;
    @(negedge clk);
    rearm = 1'b0; err_strobe = 1'b0;
    expq.delete(); lastq.delete(); hist.delete(); total = 0;
    chk("R10", "err_flag after rearm", err_flag, 0);
    chk("R10", "frozen after rearm", frozen, 0);
    chk("R10", "drop_count after rearm", drop_count, 0);
    chk("R10", "rd_valid after rearm", rd_valid, 0);
  endtask

  task automatic capture(input logic [1:0] m, input int npre, input bit err_post,
                         input int ndrop, input int drain, input bit rearm_err);
    int tl, pos, w, exp_idx;
    string req;
    tl  = (m == 2'b00) ? 0 : (m == 2'b10) ? DEPTH - 1 : DEPTH / 2;
    req = (m == 2'b00) ? "R3" : (m == 2'b10) ? "R5" : "R4";
    cap_mode = m;
    if (rearm_err) do_rearm(1'b0);
    do_rearm(rearm_err);
    for (int i = 0; i < npre; i++) drive(1'b0, 1'b1);
    chk("R6", "flag before error", err_flag, 0);
    pos = total;
    drive(1'b1, 1'b1);
    chk("R6", "flag after error", err_flag, 1);
    chk(req, "frozen after error cycle", frozen, (tl == 0) ? 1 : 0);
    for (int i = 0; i < tl; i++) begin
      drive(err_post && i == 1, 1'b1);
      if (i == tl - 2) chk(req, "frozen one before window end", frozen, 0);
    end
    chk(req, "frozen at window end", frozen, 1);
    w = (total < DEPTH) ? total : DEPTH;
    exp_idx = pos - (total - w);
    chk((total < DEPTH) ? "R11" : req, "err_index", err_index, exp_idx);
    for (int i = 0; i < ndrop; i++) drive(1'b1, 1'b0);
    chk("R7", "drop_count", drop_count, (ndrop > DMAX) ? DMAX : ndrop);
    chk("R7", "still frozen after late errors", frozen, 1);
    chk("R6", "flag holds", err_flag, 1);
    for (int i = 0; i < hist.size(); i++) begin
      expq.push_back(hist[i]);
      lastq.push_back(i == hist.size() - 1);
    end
    chk("R8", "valid when frozen", rd_valid, 1);
    if (drain == 2) begin
      rd_ready = 1'b1;
      repeat (3) @(negedge clk);
      rd_ready = 1'b0;
      @(negedge clk);
    end else begin
      for (int k = 0; k < 400 && expq.size() > 0; k++) begin
        rd_ready = (drain == 1) ? (k % 3 != 0) : 1'b1;
        @(negedge clk);
      end
      rd_ready = 1'b0;
      chk("R8", "beats left over", expq.size(), 0);
      @(negedge clk);
      chk("R8", "valid after last beat", rd_valid, 0);
    end
  endtask

  // Monitor: scoreboard pop on each accepted beat, plus stall stability.
  always begin
    @(negedge clk);
    #1;
    if (rd_valid && stall_seen) chk("R9", "stalled data", rd_data, stall_data);
    stall_seen = rd_valid && !rd_ready && !rearm;
    stall_data = rd_data;
    if (rd_valid && rd_ready && !rearm) begin
      if (expq.size() == 0) begin
        chk("R8", "unexpected beat", 1, 0);
      end else begin
        mon_exp  = expq.pop_front();
        mon_last = lastq.pop_front();
        chk("R2", "stored sample", rd_data, mon_exp);
        chk("R8", "last marker", rd_last, mon_last);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "err_flag at reset", err_flag, 0);
    chk("R1", "frozen at reset", frozen, 0);
    chk("R1", "rd_valid at reset", rd_valid, 0);
    chk("R1", "drop_count at reset", drop_count, 0);

    capture(2'b00, 20, 1'b0, 0, 1, 1'b0);   // R3 full window, throttled readout
    capture(2'b01, 30, 1'b0, 3, 0, 1'b0);   // R4 centred, a few dropped errors
    capture(2'b10, 20, 1'b1, 300, 1, 1'b0); // R5 and R7 saturation, mark inside tail
    capture(2'b11, 20, 1'b0, 0, 0, 1'b0);   // R4 alternate code
    capture(2'b00, 4, 1'b0, 0, 2, 1'b0);    // R11 short window, readout abandoned
    capture(2'b01, 3, 1'b0, 1, 1, 1'b1);    // R10 rearm colliding with an error

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule